// File: doc/BRIEF.md
# PLL power sequencing controller

This block steps a display PHY's frequency synthesizer through its bring-up and shut-down order, one register-level action per clock cycle. A one-cycle start request runs the power-up order. The bias and line buffer come on first, then the system mux code, then the PLL run control. The block then polls the lock status on a fixed microsecond grid. Once lock is seen it pulses the PHY digital reset and then opens the global clock. If lock never arrives within the timeout, the sequence stops with an error flag raised.

When master mode is selected at start, a secondary PHY gets the same bias, reset and clock steps, each directly after the corresponding step on the primary PHY. A one-cycle stop request is accepted in any state outside the shut-down order. It always runs the complete shut-down order: the clock gate is closed first, then the PLL is switched off, and then the buffer, mux code and bias are cleared. In master mode the secondary PHY follows with the same steps, except that it has no PLL run control. The frequency words and the analog loop itself are outside this block.

Named states, power-up side: IDLE, BIAS_M, MUX_M, BIAS_S, MUX_S, RUN, POLL, RSTH_M, RSTL_M, RSTH_S, RSTL_S, CTL3_M, CLK_M, CTL3_S, CLK_S, ON and FAIL.

Named states, shut-down side: GATE_M, PLLOFF, BUF_M, MUX0_M, BIAS0_M, GATE_S, BUF_S, MUX0_S and BIAS0_S.

Transitions:
- Start moves IDLE or FAIL to BIAS_M.
- Each power-up state then advances to the next one on the following cycle. The secondary (_S) states are visited only in master mode.
- POLL leaves to RSTH_M on a sample that sees lock, or to FAIL on the last sample.
- CLK_M, or CLK_S in master mode, goes to ON.
- Stop sends any state outside the shut-down side to GATE_M.
- The shut-down side walks GATE_M through BIAS0_M, then in master mode GATE_S through BIAS0_S, and returns to IDLE.

Top module: `pllseq_ctrl`

## Requirements
- R1: After reset every output is 0. A power-up first sets bias_en_o[0] and buf_en_o[0] together. In a later, separate cycle it drives sys_mux_o[7:0] to 0xC0.
- R2: The PLL run control pll_run_o goes to 1 only after the primary mux code is 0xC0. In master mode it also waits for the secondary mux code.
- R3: Lock (lock_i) is sampled only once every POLL_US (100) us_tick_i pulses counted from entry into polling. With lock already high, the reset pulse follows the 100th tick. With lock raised after tick 250, it follows tick 300.
- R4: If none of the TIMEOUT_US/POLL_US (50) samples sees lock, err_o rises after the 5000th tick. No digital reset or clock enable occurs, and busy_o drops.
- R5: After lock, dig_rst_o[0] goes high and then low. Then ctrl3_o[7:0] becomes 0x04. Then gclk_en_o[0] (gate, bit 5) and gclk_aux_o[0] (bit 4) are set together.
- R6: In master mode, PHY 1 (the upper slices) gets bias/buffer, mux 0xC0, reset pulse, 0x04 and clock bits. Each comes directly after the same step on PHY 0, and the reset pulses of both PHYs precede the first clock enable.
- R7: Shut-down order for PHY 0: clear gclk_en_o[0], clear pll_run_o, clear buf_en_o[0], set sys_mux_o[7:0] to 0, clear bias_en_o[0]. gclk_aux_o[0] keeps its value.
- R8: In master mode, shut-down then repeats the gate, buffer, mux and bias clears for PHY 1, in that order, after PHY 0 is done.
- R9: A one-cycle stop_i is accepted in IDLE, during power-up, polling, ON or FAIL, and always runs the whole shut-down order. Stop takes priority over a simultaneous start.
- R10: done_o pulses for exactly one cycle each time ON is reached. busy_o is high in every state except IDLE, ON and FAIL.
- R11: err_o stays high, through a stop, until the next accepted start. A start in FAIL clears it and reruns power-up.
- R12: A start in ON, or while busy, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle power-up request |
| stop_i | input | 1 | One-cycle power-down request |
| master_mode_i | input | 1 | Include PHY 1 in the sequence; captured at start |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| lock_i | input | 1 | PLL lock status |
| bias_en_o | output | 2 | Bias enable per PHY (bit p = PHY p) |
| buf_en_o | output | 2 | Line buffer control per PHY |
| sys_mux_o | output | 16 | System mux code, PHY p in [8p+7:8p] |
| pll_run_o | output | 1 | PLL run control (PHY 0 only) |
| dig_rst_o | output | 2 | PHY digital reset per PHY |
| ctrl3_o | output | 16 | Control register 3 value, PHY p in [8p+7:8p] |
| gclk_en_o | output | 2 | Global clock gate bit per PHY |
| gclk_aux_o | output | 2 | Second global clock bit per PHY |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on reaching ON |
| err_o | output | 1 | Lock timeout flag |

## Verification
The assertions assume the following about the inputs:
- start_i and stop_i are single-cycle pulses.
- us_tick_i is a single-cycle pulse that never lasts two cycles.
- master_mode_i is stable in the cycle a start is taken.
- lock_i may change in any cycle and is trusted only on a sample tick.

The stimulus pulses start and stop for exactly one cycle and drives the tick high on every other cycle. It raises lock at chosen tick counts, so that the sample grid and the timeout can be measured in ticks rather than cycles.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int NPHY     = 2;
    localparam int MUX_W    = 8;
    localparam int CTL_W    = 8;
    localparam logic [MUX_W-1:0] MUX_RUN  = 8'hC0;
    localparam logic [CTL_W-1:0] CTL3_VAL = 8'h04;

    typedef enum logic [4:0] {
        S_IDLE, S_BIAS_M, S_MUX_M, S_BIAS_S, S_MUX_S, S_RUN, S_POLL,
        S_RSTH_M, S_RSTL_M, S_RSTH_S, S_RSTL_S,
        S_CTL3_M, S_CLK_M, S_CTL3_S, S_CLK_S, S_ON, S_FAIL,
        S_GATE_M, S_PLLOFF, S_BUF_M, S_MUX0_M, S_BIAS0_M,
        S_GATE_S, S_BUF_S, S_MUX0_S, S_BIAS0_S
    } seq_state_e;

    // write strobes towards one PHY register bank
    typedef struct packed {
        logic bias_set;
        logic bias_clr;
        logic buf_clr;
        logic mux_set;
        logic mux_clr;
        logic rst_set;
        logic rst_clr;
        logic ctl_wr;
        logic clk_set;
        logic gate_clr;
    } bank_wr_t;

endpackage

// File: rtl/pllseq_poll_timer.sv
module pllseq_poll_timer
    import pllseq_pkg::*;
#(
    parameter int POLL_US    = 100,
    parameter int TIMEOUT_US = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic sample_o,
    output logic last_o
);

    localparam int NSAMP = TIMEOUT_US / POLL_US;
    localparam int UW    = $clog2(POLL_US + 1);
    localparam int SW    = $clog2(NSAMP + 1);
    localparam logic [UW-1:0] U_LAST = UW'(POLL_US - 1);
    localparam logic [SW-1:0] S_LAST = SW'(NSAMP - 1);

    logic [UW-1:0] us_q;
    logic [SW-1:0] smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_q  <= '0;
            smp_q <= '0;
        end else if (!run_i) begin
            us_q  <= '0;
            smp_q <= '0;
        end else if (tick_i) begin
            if (us_q == U_LAST) begin
                us_q  <= '0;
                smp_q <= smp_q + SW'(1);
            end else begin
                us_q <= us_q + UW'(1);
            end
        end
    end

    assign sample_o = run_i && tick_i && (us_q == U_LAST);
    assign last_o   = (smp_q == S_LAST);

    // R3: the sample index never passes the last sample while polling
    p_sample_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (smp_q <= S_LAST));

endmodule

// File: rtl/pllseq_phy_bank.sv
module pllseq_phy_bank
    import pllseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  bank_wr_t         wr,
    output logic             bias_o,
    output logic             buf_o,
    output logic [MUX_W-1:0] mux_o,
    output logic             rst_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             gate_o,
    output logic             aux_o
);

    logic pulsed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bias_o <= 1'b0;
            buf_o  <= 1'b0;
            mux_o  <= '0;
            rst_o  <= 1'b0;
            ctl_o  <= '0;
            gate_o <= 1'b0;
            aux_o  <= 1'b0;
        end else begin
            if (wr.bias_set) begin
                bias_o <= 1'b1;
                buf_o  <= 1'b1;
            end
            if (wr.bias_clr) bias_o <= 1'b0;
            if (wr.buf_clr)  buf_o  <= 1'b0;
            if (wr.mux_set)  mux_o  <= MUX_RUN;
            if (wr.mux_clr)  mux_o  <= '0;
            if (wr.rst_set)  rst_o  <= 1'b1;
            if (wr.rst_clr)  rst_o  <= 1'b0;
            if (wr.ctl_wr)   ctl_o  <= CTL3_VAL;
            if (wr.clk_set) begin
                gate_o <= 1'b1;
                aux_o  <= 1'b1;
            end
            if (wr.gate_clr) gate_o <= 1'b0;
        end
    end

    // tracks a completed reset pulse since the bias last went down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      pulsed_q <= 1'b0;
        else if (wr.bias_clr)            pulsed_q <= 1'b0;
        else if (rst_o && wr.rst_clr)    pulsed_q <= 1'b1;
    end

    // R1: mux code reaches 0xC0 only with the bias on
    p_mux_after_bias_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mux_o == MUX_RUN) |-> bias_o);

    // R5: clock gate opens only after a full reset pulse
    p_rst_before_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> (pulsed_q && !rst_o));

    // R7: bias is the last thing to go down
    p_bias_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bias_o) |-> (mux_o == '0 && !buf_o && !gate_o));

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
    import pllseq_pkg::*;
#(
    parameter int TIMEOUT_US = 5000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     stop_i,
    input  logic     master_mode_i,
    input  logic     lock_i,
    input  logic     us_tick_i,
    input  logic     sample_i,
    input  logic     last_i,
    output bank_wr_t wr_m_o,
    output bank_wr_t wr_s_o,
    output logic     run_set_o,
    output logic     run_clr_o,
    output logic     poll_run_o,
    output logic     busy_o,
    output logic     done_o,
    output logic     err_o
);

    seq_state_e state_q, state_d;
    logic       slave_q;
    logic       in_down;
    logic       take_start;

    always_comb begin
        unique case (state_q)
            S_GATE_M, S_PLLOFF, S_BUF_M, S_MUX0_M, S_BIAS0_M,
            S_GATE_S, S_BUF_S, S_MUX0_S, S_BIAS0_S: in_down = 1'b1;
            default:                                in_down = 1'b0;
        endcase
    end

    assign take_start = start_i && !stop_i &&
                        (state_q == S_IDLE || state_q == S_FAIL);

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (stop_i && !in_down) begin
            state_d = S_GATE_M;
        end else begin
            unique case (state_q)
                S_IDLE:    if (take_start) state_d = S_BIAS_M;
                S_BIAS_M:  state_d = S_MUX_M;
                S_MUX_M:   state_d = slave_q ? S_BIAS_S : S_RUN;
                S_BIAS_S:  state_d = S_MUX_S;
                S_MUX_S:   state_d = S_RUN;
                S_RUN:     state_d = S_POLL;
                S_POLL: begin
                    if (sample_i && lock_i)     state_d = S_RSTH_M;
                    else if (sample_i && last_i) state_d = S_FAIL;
                end
                S_RSTH_M:  state_d = S_RSTL_M;
                S_RSTL_M:  state_d = slave_q ? S_RSTH_S : S_CTL3_M;
                S_RSTH_S:  state_d = S_RSTL_S;
                S_RSTL_S:  state_d = S_CTL3_M;
                S_CTL3_M:  state_d = S_CLK_M;
                S_CLK_M:   state_d = slave_q ? S_CTL3_S : S_ON;
                S_CTL3_S:  state_d = S_CLK_S;
                S_CLK_S:   state_d = S_ON;
                S_ON:      state_d = S_ON;
                S_FAIL:    if (take_start) state_d = S_BIAS_M;
                S_GATE_M:  state_d = S_PLLOFF;
                S_PLLOFF:  state_d = S_BUF_M;
                S_BUF_M:   state_d = S_MUX0_M;
                S_MUX0_M:  state_d = S_BIAS0_M;
                S_BIAS0_M: state_d = slave_q ? S_GATE_S : S_IDLE;
                S_GATE_S:  state_d = S_BUF_S;
                S_BUF_S:   state_d = S_MUX0_S;
                S_MUX0_S:  state_d = S_BIAS0_S;
                S_BIAS0_S: state_d = S_IDLE;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    // state register with mode capture, done pulse and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            slave_q <= 1'b0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= (state_d == S_ON) && (state_q != S_ON);
            if (take_start) begin
                slave_q <= master_mode_i;
                err_o   <= 1'b0;
            end else if (state_q == S_POLL && state_d == S_FAIL) begin
                err_o   <= 1'b1;
            end
        end
    end

    // per-state register write strobes
    always_comb begin
        wr_m_o     = '0;
        wr_s_o     = '0;
        run_set_o  = 1'b0;
        run_clr_o  = 1'b0;
        poll_run_o = 1'b0;
        unique case (state_q)
            S_BIAS_M:  wr_m_o.bias_set = 1'b1;
            S_MUX_M:   wr_m_o.mux_set  = 1'b1;
            S_BIAS_S:  wr_s_o.bias_set = 1'b1;
            S_MUX_S:   wr_s_o.mux_set  = 1'b1;
            S_RUN:     run_set_o       = 1'b1;
            S_POLL:    poll_run_o      = 1'b1;
            S_RSTH_M:  wr_m_o.rst_set  = 1'b1;
            S_RSTL_M:  wr_m_o.rst_clr  = 1'b1;
            S_RSTH_S:  wr_s_o.rst_set  = 1'b1;
            S_RSTL_S:  wr_s_o.rst_clr  = 1'b1;
            S_CTL3_M:  wr_m_o.ctl_wr   = 1'b1;
            S_CLK_M:   wr_m_o.clk_set  = 1'b1;
            S_CTL3_S:  wr_s_o.ctl_wr   = 1'b1;
            S_CLK_S:   wr_s_o.clk_set  = 1'b1;
            S_GATE_M:  wr_m_o.gate_clr = 1'b1;
            S_PLLOFF:  run_clr_o       = 1'b1;
            S_BUF_M:   wr_m_o.buf_clr  = 1'b1;
            S_MUX0_M:  wr_m_o.mux_clr  = 1'b1;
            S_BIAS0_M: wr_m_o.bias_clr = 1'b1;
            S_GATE_S:  wr_s_o.gate_clr = 1'b1;
            S_BUF_S:   wr_s_o.buf_clr  = 1'b1;
            S_MUX0_S:  wr_s_o.mux_clr  = 1'b1;
            S_BIAS0_S: wr_s_o.bias_clr = 1'b1;
            default: ;
        endcase
    end

    assign busy_o = !(state_q == S_IDLE || state_q == S_ON || state_q == S_FAIL);

    // independent microsecond count while polling, for the timeout window
    localparam int TW = $clog2(TIMEOUT_US + 2);
    logic [TW-1:0] poll_us_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         poll_us_q <= '0;
        else if (state_q != S_POLL)         poll_us_q <= '0;
        else if (us_tick_i)                 poll_us_q <= poll_us_q + TW'(1);
    end

    // R4: polling never outlasts the timeout
    p_timeout_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POLL) |-> (poll_us_q < TW'(TIMEOUT_US)));

    // R3: leaving polling towards reset requires lock in that cycle
    p_lock_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RSTH_M && $past(state_q) == S_POLL) |-> $past(lock_i));

    // R10: done is a single-cycle pulse
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: error clears only on a start
    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> $past(start_i));

    // R9: stop outside shut-down always enters the gate step
    p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !in_down) |=> (state_q == S_GATE_M));

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
    import pllseq_pkg::*;
#(
    parameter int POLL_US    = 100,
    parameter int TIMEOUT_US = 5000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  master_mode_i,
    input  logic                  us_tick_i,
    input  logic                  lock_i,
    output logic [NPHY-1:0]       bias_en_o,
    output logic [NPHY-1:0]       buf_en_o,
    output logic [NPHY*MUX_W-1:0] sys_mux_o,
    output logic                  pll_run_o,
    output logic [NPHY-1:0]       dig_rst_o,
    output logic [NPHY*CTL_W-1:0] ctrl3_o,
    output logic [NPHY-1:0]       gclk_en_o,
    output logic [NPHY-1:0]       gclk_aux_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  err_o
);

    bank_wr_t wr_bank [NPHY];
    logic     run_set, run_clr, poll_run, sample, last;

    pllseq_poll_timer #(
        .POLL_US    (POLL_US),
        .TIMEOUT_US (TIMEOUT_US)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (poll_run),
        .tick_i   (us_tick_i),
        .sample_o (sample),
        .last_o   (last)
    );

    pllseq_fsm #(
        .TIMEOUT_US (TIMEOUT_US)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .stop_i        (stop_i),
        .master_mode_i (master_mode_i),
        .lock_i        (lock_i),
        .us_tick_i     (us_tick_i),
        .sample_i      (sample),
        .last_i        (last),
        .wr_m_o        (wr_bank[0]),
        .wr_s_o        (wr_bank[1]),
        .run_set_o     (run_set),
        .run_clr_o     (run_clr),
        .poll_run_o    (poll_run),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .err_o         (err_o)
    );

    for (genvar p = 0; p < NPHY; p++) begin : g_bank
        pllseq_phy_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_bank[p]),
            .bias_o (bias_en_o[p]),
            .buf_o  (buf_en_o[p]),
            .mux_o  (sys_mux_o[p*MUX_W +: MUX_W]),
            .rst_o  (dig_rst_o[p]),
            .ctl_o  (ctrl3_o[p*CTL_W +: CTL_W]),
            .gate_o (gclk_en_o[p]),
            .aux_o  (gclk_aux_o[p])
        );
    end

    // PLL run control exists on the primary PHY only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pll_run_o <= 1'b0;
        else if (run_set) pll_run_o <= 1'b1;
        else if (run_clr) pll_run_o <= 1'b0;
    end

    // R2: run starts with the primary bias on and mux at 0xC0
    p_run_after_mux_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_run_o) |-> (bias_en_o[0] && sys_mux_o[MUX_W-1:0] == MUX_RUN));

    // R7: the PLL is switched off only with the primary clock gated
    p_gate_before_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_run_o) |-> !gclk_en_o[0]);

    // R6: secondary clock opens only after the primary one
    p_slave_after_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gclk_en_o[1]) |-> gclk_en_o[0]);

    // R8: secondary bias drops only after the primary one
    p_slave_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bias_en_o[1]) |-> (!bias_en_o[0] && !pll_run_o));

endmodule

// File: tb/test_pllseq_ctrl.sv
module test_pllseq_ctrl;

    localparam int SNW = 44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, master_mode_i = 1'b0;
    logic        us_tick_i = 1'b0, lock_i = 1'b0;
    logic [1:0]  bias_en_o, buf_en_o, dig_rst_o, gclk_en_o, gclk_aux_o;
    logic [15:0] sys_mux_o, ctrl3_o;
    logic        pll_run_o, busy_o, done_o, err_o;

    pllseq_ctrl i_pllseq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .master_mode_i(master_mode_i), .us_tick_i(us_tick_i), .lock_i(lock_i),
        .bias_en_o(bias_en_o), .buf_en_o(buf_en_o), .sys_mux_o(sys_mux_o),
        .pll_run_o(pll_run_o), .dig_rst_o(dig_rst_o), .ctrl3_o(ctrl3_o),
        .gclk_en_o(gclk_en_o), .gclk_aux_o(gclk_aux_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // model of the expected output state
    logic [1:0]  m_bias = '0, m_buf = '0, m_rst = '0, m_gate = '0, m_aux = '0;
    logic [15:0] m_mux = '0, m_ctl = '0;
    logic        m_run = 1'b0, m_err = 1'b0;
    logic [SNW-1:0] last_push = '0;
    logic [SNW-1:0] exp_q[$];
    string          tag_q[$];

    function automatic logic [SNW-1:0] model_snap();
        return {m_err, m_buf, m_aux, m_gate, m_ctl, m_rst, m_run, m_mux, m_bias};
    endfunction

    function automatic logic [SNW-1:0] dut_snap();
        return {err_o, buf_en_o, gclk_aux_o, gclk_en_o, ctrl3_o, dig_rst_o, pll_run_o, sys_mux_o, bias_en_o};
    endfunction

    task automatic push(input string tag);
        logic [SNW-1:0] s;
        s = model_snap();
        if (s != last_push) begin
            exp_q.push_back(s);
            tag_q.push_back(tag);
            last_push = s;
        end
    endtask

    task automatic up_seq(input bit sl);
        m_bias[0] = 1; m_buf[0] = 1; push("R1");
        m_mux[7:0] = 8'hC0; push("R1");
        if (sl) begin
            m_bias[1] = 1; m_buf[1] = 1; push("R6");
            m_mux[15:8] = 8'hC0; push("R6");
        end
        m_run = 1; push("R2");
    endtask

    task automatic lock_seq(input bit sl);
        m_rst[0] = 1; push("R5");
        m_rst[0] = 0; push("R5");
        if (sl) begin
            m_rst[1] = 1; push("R6");
            m_rst[1] = 0; push("R6");
        end
        m_ctl[7:0] = 8'h04; push("R5");
        m_gate[0] = 1; m_aux[0] = 1; push("R5");
        if (sl) begin
            m_ctl[15:8] = 8'h04; push("R6");
            m_gate[1] = 1; m_aux[1] = 1; push("R6");
        end
    endtask

    task automatic down_seq(input bit sl);
        m_gate[0] = 0; push("R7");
        m_run = 0; push("R7");
        m_buf[0] = 0; push("R7");
        m_mux[7:0] = 8'h00; push("R7");
        m_bias[0] = 0; push("R7");
        if (sl) begin
            m_gate[1] = 0; push("R8");
            m_buf[1] = 0; push("R8");
            m_mux[15:8] = 8'h00; push("R8");
            m_bias[1] = 0; push("R8");
        end
    endtask

    // monitor state
    logic [SNW-1:0] prev_snap = '0;
    logic prev_run = 1'b0, prev_done = 1'b0, counting = 1'b0, busy_seen = 1'b0;
    int   poll_ticks = 0, done_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic [SNW-1:0] cur;
            cur = dut_snap();
            if (cur != prev_snap) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "unexpected output change (R12)", 64'(cur), 64'(prev_snap));
                end else begin
                    logic [SNW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cur == e, t, 64'(cur), 64'(e));
                end
            end
            prev_snap = cur;
            if (done_o) begin
                done_cnt++;
                if (prev_done) chk(1'b0, "R10 done wider than one cycle", 2, 1);
            end
            prev_done = done_o;
            if (busy_o) busy_seen = 1'b1;
            if (pll_run_o && !prev_run) begin
                counting = 1'b1;
                poll_ticks = us_tick_i ? 1 : 0;
            end else if (counting) begin
                if (dig_rst_o[0] || err_o) counting = 1'b0;
                else if (us_tick_i) poll_ticks++;
            end
            prev_run = pll_run_o;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            us_tick_i = ~us_tick_i;
        end
    end

    task automatic do_start(input bit mode);
        @(negedge clk);
        master_mode_i = mode;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        chk(exp_q.size() == 0, tag, 64'(exp_q.size()), 0);
    endtask

    bit summary_done = 0;

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dut_snap() == '0 && !busy_o && !done_o, "R1 reset state", 64'(dut_snap()), 0);

        // standalone, lock present from the start
        lock_i = 1'b1;
        up_seq(0);
        lock_seq(0);
        do_start(0);
        wait_idle();
        drained("R5 standalone sequence");
        chk(done_cnt == 1, "R10 done count", done_cnt, 1);
        chk(poll_ticks == 100, "R3 first sample", poll_ticks, 100);
        chk(!busy_o, "R10 busy low in ON", busy_o, 0);

        // start while ON is ignored
        do_start(1);
        repeat (30) @(negedge clk);
        drained("R12 start in ON");
        chk(done_cnt == 1, "R12 no second done", done_cnt, 1);

        // shut down standalone
        down_seq(0);
        do_stop();
        wait_idle();
        drained("R7 shut-down order");
        chk(gclk_aux_o[0] == 1'b1, "R7 aux bit kept", gclk_aux_o, 1);

        // master mode, lock arrives late
        lock_i = 1'b0;
        up_seq(1);
        lock_seq(1);
        do_start(1);
        while (!(counting && poll_ticks >= 250)) @(negedge clk);
        // start while busy is ignored
        do_start(0);
        lock_i = 1'b1;
        wait_idle();
        drained("R6 master sequence");
        chk(poll_ticks == 300, "R3 sample grid", poll_ticks, 300);
        chk(done_cnt == 2, "R10 done count master", done_cnt, 2);

        // master shut-down
        down_seq(1);
        do_stop();
        wait_idle();
        drained("R8 secondary shut-down");

        // timeout
        lock_i = 1'b0;
        up_seq(0);
        m_err = 1; push("R4");
        do_start(0);
        wait_idle();
        drained("R4 timeout sequence");
        chk(poll_ticks == 5000, "R4 timeout ticks", poll_ticks, 5000);
        chk(err_o && !dig_rst_o[0] && !gclk_en_o[0], "R4 no reset or clock", {err_o, dig_rst_o[0], gclk_en_o[0]}, 3'b100);
        chk(done_cnt == 2, "R4 no done", done_cnt, 2);
        repeat (20) @(negedge clk);
        chk(err_o == 1'b1, "R11 err held", err_o, 1);

        // restart from FAIL
        lock_i = 1'b1;
        m_err = 0; push("R11");
        up_seq(0);
        lock_seq(0);
        do_start(0);
        wait_idle();
        drained("R11 restart from fail");
        chk(!err_o && done_cnt == 3, "R11 err cleared and done", {err_o, 4'(done_cnt)}, 5'h03);

        down_seq(0);
        do_stop();
        wait_idle();
        drained("R7 second shut-down");

        // stop during polling in master mode
        lock_i = 1'b0;
        up_seq(1);
        down_seq(1);
        do_start(1);
        while (!(counting && poll_ticks >= 20)) @(negedge clk);
        do_stop();
        wait_idle();
        drained("R9 stop while polling");
        chk(done_cnt == 3 && !err_o, "R9 no done after stop", 4'(done_cnt), 3);

        // stop one cycle after start
        m_bias[0] = 1; m_buf[0] = 1; push("R9");
        down_seq(0);
        @(negedge clk);
        master_mode_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        wait_idle();
        drained("R9 stop during power-up");
        chk(sys_mux_o == 16'h0 && !pll_run_o, "R9 mux never set", 64'(sys_mux_o), 0);

        // start and stop together in IDLE: stop wins
        busy_seen = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stop_i = 1'b0;
        wait_idle();
        chk(busy_seen, "R9 stop in idle runs shut-down", busy_seen, 1);
        chk(!bias_en_o[0] && !pll_run_o, "R9 stop beats start", {bias_en_o[0], pll_run_o}, 0);
        drained("R9 stop in idle");

        // timeout, then stop keeps error
        up_seq(0);
        m_err = 1; push("R4");
        do_start(0);
        wait_idle();
        down_seq(0);
        do_stop();
        wait_idle();
        drained("R11 stop from fail");
        chk(err_o == 1'b1, "R11 err survives stop", err_o, 1);

        summary();
        $finish;
    end

endmodule